// File: doc/BRIEF.md
# Bit-level pipelined array multiplier

This block multiplies two unsigned W-bit operands and returns the exact 2W-bit product. It accepts one operand pair on every clock edge, marked by a valid flag. The result leaves a fixed number of cycles later, with its own valid flag. Inside, a chain of carry-save rows reduces the partial products, one multiplier bit per row, and a register stage sits after every row. Each carry-save row also forms, with an AND gate, the partial product that the following row adds. That product is registered before use, so no stage holds more than one full-adder delay.

After the last carry-save row, the sum and carry vectors pass through rows of half adders, one row per stage, until no saved carry is left. A final XOR row then gives the product. The operand bits still needed downstream travel in shift registers beside the data, so all bits of one result leave together. The latency is 3W cycles, counting the capture edge: 1 input stage, W carry-save rows, 2W-2 half-adder rows and 1 output stage.

Top module: `pmul_array`

## Requirements
- R1: For every pair of unsigned operands, `product_o` equals `mcand_i * mplier_i` as a 2W-bit value, with no truncation.
- R2: A pair captured while `valid_i` is high appears on the outputs after exactly 3W rising edges, counting the capture edge, and not one cycle earlier.
- R3: `valid_o` reproduces the `valid_i` sequence delayed by 3W cycles, including bubbles between valid pairs.
- R4: A new operand pair can be accepted on every edge, and back-to-back pairs give back-to-back correct results.
- R5: While `rst_ni` is low, `valid_o` and `product_o` are both zero, whatever the inputs are.
- R6: The full-adder cell has inputs x, y and z. For combination k from 0 to 7, x is bit 0 of k, y is bit 1 and z is bit 2. Read in order of k, the sum output is 01101001 and the carry output is 00010111.
- R7: The half-adder cell has inputs x and y. For combination k from 0 to 3, x is bit 0 of k and y is bit 1. Read in order of k, the sum is 0110 and the carry is 0001.
- R8: Corner operands give the exact product: zero, all ones (largest product (2^W-1)^2), and single set bits. A valid product never exceeds (2^W-1)^2.
- R9: During the first 3W edges after reset is released, `valid_o` stays low even if `valid_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks the operand pair as valid |
| mcand_i | input | W | Multiplicand, unsigned |
| mplier_i | input | W | Multiplier, unsigned |
| valid_o | output | 1 | Marks the product as valid |
| product_o | output | 2W | Unsigned product |

## Verification
The bench builds two copies of the multiplier side by side. The first uses W=4, a 12-cycle pipe, and all 256 operand pairs are streamed through it back to back. The second uses W=2, a 6-cycle pipe, and is fed slices of the same operands, so it also sees every pair, with a different number of carry-save and half-adder rows. Both cell types are tested alone over their full truth tables. Isolated pairs and bubble patterns pin down the exact cycle on which the valid flag rises.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  // cycles from capture edge to registered product
  function automatic int unsigned pipe_depth(int unsigned w);
    return 3 * w;
  endfunction
  // half-adder rows needed before the final xor row
  function automatic int unsigned merge_rows(int unsigned w);
    return 2 * w - 2;
  endfunction
endpackage

// File: rtl/pmul_fa_cell.sv
module pmul_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic sum_o,
  output logic cry_o
);
  assign sum_o = x_i ^ y_i ^ z_i;
  assign cry_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
endmodule

// File: rtl/pmul_ha_cell.sv
module pmul_ha_cell (
  input  logic x_i,
  input  logic y_i,
  output logic sum_o,
  output logic cry_o
);
  assign sum_o = x_i ^ y_i;
  assign cry_o = x_i & y_i;
endmodule

// File: rtl/pmul_csa_row.sv
module pmul_csa_row #(
  parameter int unsigned P = 8
) (
  input  logic [P-1:0] s_i,
  input  logic [P-1:0] c_i,
  input  logic [P-1:0] pp_i,
  output logic [P-1:0] s_o,
  output logic [P-1:0] c_o
);
  logic [P-1:0] sm;
  logic [P-2:0] cy;

  for (genvar i = 0; i < P; i++) begin : g_bit
    if (i < P - 1) begin : g_fa
      pmul_fa_cell u_fa (
        .x_i  (s_i[i]),
        .y_i  (c_i[i]),
        .z_i  (pp_i[i]),
        .sum_o(sm[i]),
        .cry_o(cy[i])
      );
    end else begin : g_top
      // carry out of the msb lies beyond the product width
      assign sm[i] = s_i[i] ^ c_i[i] ^ pp_i[i];
    end
  end

  assign s_o = sm;
  assign c_o = {cy, 1'b0};
endmodule

// File: rtl/pmul_ha_stage.sv
module pmul_ha_stage #(
  parameter int unsigned P = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [P-1:0] s_i,
  input  logic [P-1:0] c_i,
  output logic [P-1:0] s_o,
  output logic [P-1:0] c_o
);
  logic [P-1:0] sm;
  logic [P-2:0] cy;

  for (genvar i = 0; i < P; i++) begin : g_bit
    if (i < P - 1) begin : g_ha
      pmul_ha_cell u_ha (
        .x_i  (s_i[i]),
        .y_i  (c_i[i]),
        .sum_o(sm[i]),
        .cry_o(cy[i])
      );
    end else begin : g_top
      assign sm[i] = s_i[i] ^ c_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_o <= '0;
      c_o <= '0;
    end else begin
      s_o <= sm;
      c_o <= {cy, 1'b0};
    end
  end
endmodule

// File: rtl/pmul_array.sv
module pmul_array
  import pmul_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           valid_o,
  output logic [2*W-1:0] product_o
);
  localparam int unsigned P   = 2 * W;
  localparam int unsigned LAT = pipe_depth(W);
  localparam int unsigned MR  = merge_rows(W);

  // input stage: first partial product and operand skew entry 0
  logic [P-1:0] pp0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pp0_q <= '0;
    else         pp0_q <= {{W{1'b0}}, mcand_i & {W{mplier_i[0]}}};
  end

  // operand skew: entry e feeds the AND of carry-save row e
  for (genvar e = 0; e < W - 1; e++) begin : g_op
    logic [W-1:0]   a_q;
    logic [W-1:e+1] b_q;
    if (e == 0) begin : g_load
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          a_q <= '0;
          b_q <= '0;
        end else begin
          a_q <= mcand_i;
          b_q <= mplier_i[W-1:1];
        end
      end
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          a_q <= '0;
          b_q <= '0;
        end else begin
          a_q <= g_op[e-1].a_q;
          b_q <= g_op[e-1].b_q[W-1:e+1];
        end
      end
    end
  end

  // carry-save rows, one per multiplier bit
  for (genvar k = 0; k < W; k++) begin : g_row
    logic [P-1:0] s_in, c_in, pp_in, s_cmb, c_cmb, s_q, c_q;

    if (k == 0) begin : g_first
      assign s_in  = '0;
      assign c_in  = '0;
      assign pp_in = pp0_q;
    end else begin : g_chain
      assign s_in  = g_row[k-1].s_q;
      assign c_in  = g_row[k-1].c_q;
      assign pp_in = g_row[k-1].g_pp.pp_q;
    end

    pmul_csa_row #(.P(P)) u_csa (
      .s_i (s_in),
      .c_i (c_in),
      .pp_i(pp_in),
      .s_o (s_cmb),
      .c_o (c_cmb)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_q <= '0;
        c_q <= '0;
      end else begin
        s_q <= s_cmb;
        c_q <= c_cmb;
      end
    end

    // partial product for the next row, formed here and registered
    if (k < W - 1) begin : g_pp
      logic [P-1:0] pp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pp_q <= '0;
        else pp_q <= {{W{1'b0}}, g_op[k].a_q & {W{g_op[k].b_q[k+1]}}} << (k + 1);
      end
    end
  end

  // half-adder merge rows
  for (genvar j = 0; j < MR; j++) begin : g_mrg
    logic [P-1:0] s_in, c_in, s_o, c_o;
    if (j == 0) begin : g_first
      assign s_in = g_row[W-1].s_q;
      assign c_in = g_row[W-1].c_q;
    end else begin : g_chain
      assign s_in = g_mrg[j-1].s_o;
      assign c_in = g_mrg[j-1].c_o;
    end
    pmul_ha_stage #(.P(P)) u_ha (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .s_i   (s_in),
      .c_i   (c_in),
      .s_o   (s_o),
      .c_o   (c_o)
    );
  end

  // final row: only the msb may still hold a carry
  logic [P-1:0] fin_s, fin_c, prod_q;
  assign fin_s = g_mrg[MR-1].s_o;
  assign fin_c = g_mrg[MR-1].c_o;

  logic [LAT-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      vld_q  <= '0;
    end else begin
      prod_q <= fin_s ^ fin_c;
      vld_q  <= {vld_q[LAT-2:0], valid_i};
    end
  end

  assign product_o = prod_q;
  assign valid_o   = vld_q[LAT-1];
endmodule

// File: rtl/pmul_array_chk.sv
module pmul_array_chk
  import pmul_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [W-1:0]   mcand_i,
  input logic [W-1:0]   mplier_i,
  input logic           valid_o,
  input logic [2*W-1:0] product_o
);
  localparam int unsigned P   = 2 * W;
  localparam int unsigned LAT = pipe_depth(W);
  localparam int unsigned CW  = $clog2(LAT + 1);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [P-1:0] MAXP = P'(ONES) * P'(ONES);

  logic [P-1:0]   exp_q [LAT];
  logic [LAT-1:0] ev_q;
  logic [CW-1:0]  fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) exp_q[i] <= '0;
      ev_q   <= '0;
      fill_q <= '0;
    end else begin
      exp_q[0] <= P'(mcand_i) * P'(mplier_i);
      for (int i = 1; i < LAT; i++) exp_q[i] <= exp_q[i-1];
      ev_q   <= {ev_q[LAT-2:0], valid_i};
      fill_q <= (fill_q == CW'(LAT)) ? fill_q : fill_q + 1'b1;
    end
  end

  p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> product_o == exp_q[LAT-1]);

  p_valid_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == ev_q[LAT-1]);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> product_o <= MAXP);

  p_fill_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q < CW'(LAT)) |-> !valid_o);
endmodule

bind pmul_array pmul_array_chk #(.W(W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .valid_o  (valid_o),
  .product_o(product_o)
);

// File: tb/test_pmul_array.sv
module test_pmul_array;
  localparam int L4 = 3 * 4;
  localparam int L2 = 3 * 2;
  localparam int HN = 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       vld;
  logic [3:0] a4, b4;
  logic [1:0] a2, b2;
  logic       vo4, vo2;
  logic [7:0] p4;
  logic [3:0] p2;

  pmul_array #(.W(4)) i_pmul_array (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld),
    .mcand_i(a4), .mplier_i(b4), .valid_o(vo4), .product_o(p4)
  );

  pmul_array #(.W(2)) i_pmul_array_w2 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld),
    .mcand_i(a2), .mplier_i(b2), .valid_o(vo2), .product_o(p2)
  );

  logic fx, fy, fz, fs, fc, hx, hy, hs, hc;
  pmul_fa_cell i_fa (.x_i(fx), .y_i(fy), .z_i(fz), .sum_o(fs), .cry_o(fc));
  pmul_ha_cell i_ha (.x_i(hx), .y_i(hy), .sum_o(hs), .cry_o(hc));

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  logic       h_v  [HN];
  logic [7:0] h_p4 [HN];
  logic [3:0] h_p2 [HN];
  string      h_tag[HN];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [3:0] a,
                      input logic [3:0] b, input string tag);
    logic ev;
    @(negedge clk);
    if (!rst_n) begin
      chk(vo4 == 1'b0, "R5", "w4 valid in reset", vo4, 0);
      chk(p4 == 8'd0, "R5", "w4 product in reset", p4, 0);
      chk(vo2 == 1'b0, "R5", "w2 valid in reset", vo2, 0);
      chk(p2 == 4'd0, "R5", "w2 product in reset", p2, 0);
    end else begin
      ev = (cyc >= L4) ? h_v[cyc-L4] : 1'b0;
      chk(vo4 == ev, "R2 R3 R9", $sformatf("w4 valid cyc %0d", cyc), vo4, ev);
      if (ev) chk(p4 == h_p4[cyc-L4], h_tag[cyc-L4],
                  $sformatf("w4 product cyc %0d", cyc), p4, h_p4[cyc-L4]);
      ev = (cyc >= L2) ? h_v[cyc-L2] : 1'b0;
      chk(vo2 == ev, "R2 R3 R9", $sformatf("w2 valid cyc %0d", cyc), vo2, ev);
      if (ev) chk(p2 == h_p2[cyc-L2], h_tag[cyc-L2],
                  $sformatf("w2 product cyc %0d", cyc), p2, h_p2[cyc-L2]);
    end
    rst_n = r;
    vld   = v;
    a4    = a;
    b4    = b;
    a2    = a[3:2];
    b2    = b[1:0];
    h_v[cyc]   = r & v;
    h_p4[cyc]  = 8'(a) * 8'(b);
    h_p2[cyc]  = 4'(a[3:2]) * 4'(b[1:0]);
    h_tag[cyc] = tag;
    cyc++;
  endtask

  localparam logic [7:0] FA_SUM = 8'b01101001;
  localparam logic [7:0] FA_CRY = 8'b00010111;
  localparam logic [3:0] HA_SUM = 4'b0110;
  localparam logic [3:0] HA_CRY = 4'b0001;

  logic [3:0] ca [10] = '{4'd0, 4'd15, 4'd1, 4'd8, 4'd15, 4'd1, 4'd0, 4'd15, 4'd2, 4'd8};
  logic [3:0] cb [10] = '{4'd0, 4'd15, 4'd1, 4'd8, 4'd1, 4'd15, 4'd15, 4'd0, 4'd4, 4'd15};

  initial begin
    rst_n = 1'b0; vld = 1'b0; a4 = '0; b4 = '0; a2 = '0; b2 = '0;
    for (int k = 0; k < 8; k++) begin
      fx = k[0]; fy = k[1]; fz = k[2];
      #1;
      chk(fs == FA_SUM[7-k], "R6", $sformatf("fa sum k=%0d", k), fs, FA_SUM[7-k]);
      chk(fc == FA_CRY[7-k], "R6", $sformatf("fa carry k=%0d", k), fc, FA_CRY[7-k]);
    end
    for (int k = 0; k < 4; k++) begin
      hx = k[0]; hy = k[1];
      #1;
      chk(hs == HA_SUM[3-k], "R7", $sformatf("ha sum k=%0d", k), hs, HA_SUM[3-k]);
      chk(hc == HA_CRY[3-k], "R7", $sformatf("ha carry k=%0d", k), hc, HA_CRY[3-k]);
    end
    // reset held with live inputs (R5), then release with valid high (R9)
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 4'd15, 4'd15, "R5");
    // exhaustive stream, back to back (R1 R4)
    for (int i = 0; i < 256; i++) step(1'b1, 1'b1, 4'(i >> 4), 4'(i), "R1 R4");
    // corners with bubbles (R3 R8)
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 1'b1, ca[i], cb[i], "R8");
      step(1'b1, 1'b0, 4'd5, 4'd10, "R3");
    end
    // isolated pair after idle (R2)
    for (int i = 0; i < L4 + 2; i++) step(1'b1, 1'b0, 4'd0, 4'd0, "R3");
    step(1'b1, 1'b1, 4'd13, 4'd11, "R2");
    for (int i = 0; i < L4 + 3; i++) step(1'b1, 1'b0, 4'd0, 4'd0, "R3");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule